// File: doc/BRIEF.md
# Delta Huffman Compression Packer

This block turns a stream of 8-bit sensor readings into a dense bit-packed form for a narrow retention memory. Each accepted reading is replaced by its two's-complement difference from the reading before it in the same block. The difference is then mapped to a prefix-free code of 1 to 13 bits. Slowly changing data, such as periodic temperature logs, produces mostly differences of 0 and ±1, and these get the shortest codes. Codes are appended, first bit at the lowest position, into a 51-bit staging buffer.

Work is organised in blocks of 16 readings. The buffer is handed out on the flush port when the sixteenth reading of a block has been packed. It is also handed out early when the next code would overrun the 51 bits, in which case that code opens the emptied buffer at bit 0. Each flush carries the packed bits, how many of them are valid, and a flag marking the final flush of a block. A block-start pulse clears the predictor and the block position, so each block decodes on its own.

Top module: `delta_huff_packer`

## Requirements
- R1: After reset, `flush_valid_o` is low, `smp_ready_o` is high, the staging buffer is empty and the predictor holds zero.
- R2: The value coded for an accepted sample is `(sample - prev) mod 256`. `prev` is the previous accepted sample of the same block, or zero for the first sample of a block.
- R3: Code table, written as value/length with code bit 0 sent first. A delta of 0 gives 0/1. +1 gives 1/3 and -1 gives 5/3. +2 gives 3/4 and -2 gives 11/4. A magnitude m in 3..6 gives `7 + 16*s + 32*(m-3)` with length 7, where s is 1 for negative. Any other delta d gives `15 + 32*d` with length 13.
- R4: A code is placed starting at bit position equal to the current fill count, and the fill count grows by the code length. Flushed bits at or above `flush_bits_o` are zero.
- R5: The sample that completes 16 accepted samples of a block produces a flush in the next cycle with `flush_end_o`=1. That flush includes the sample's code, and the buffer is empty afterwards.
- R6: If fill plus code length would exceed 51, the next cycle flushes the old buffer with its fill count and `flush_end_o`=0. The new code then starts at bit 0 of the emptied buffer.
- R7: If the sixteenth sample also overflows, the overflow flush (`flush_end_o`=0) comes first while `smp_ready_o` is low for that one cycle. The following cycle carries a flush of that single code with `flush_end_o`=1, and ready returns high.
- R8: `blk_start_i` clears the predictor, the block position, the buffer and any pending flush. A sample accepted in the same cycle is treated as the first sample of the new block.
- R9: Cycles where `smp_valid_i` is low leave the predictor, buffer and block position unchanged and produce no flush. Each flush is valid for exactly one cycle.
- R10: Delta arithmetic wraps modulo 256. For example, 0xFF followed by 0x00 codes as +1, and 0x7F followed by 0xFF codes as -128 (escape).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start_i | input | 1 | Begin a new block (clears predictor, position, buffer) |
| smp_valid_i | input | 1 | Sample present |
| smp_ready_o | output | 1 | Sample can be accepted this cycle |
| smp_data_i | input | 8 | Sample value |
| flush_valid_o | output | 1 | Flush port carries a buffer this cycle |
| flush_data_o | output | 51 | Packed code bits, first code at bit 0 |
| flush_bits_o | output | 6 | Number of valid bits in `flush_data_o` |
| flush_end_o | output | 1 | This flush closes the block |

## Verification
The bench targets the overflow boundary. A design that tests fill against the limit with the wrong inequality would either drop bits at exactly 51 or flush one code too early, leaving a 13-bit escape misplaced. It also drives a block whose sixteenth sample overflows, where a design without the one-cycle stall would lose either the old buffer or the closing code. Further tests cover wraparound deltas near ±128 and the ±6/±7 edge between the mid and escape codes, where a wrong sign or magnitude test produces a different code length. Block-start tests, with and without a simultaneous sample, show whether a stale predictor or partial buffer leaks into the next block.

// File: rtl/dhp_pkg.sv
// Shared definitions for the delta Huffman packer.
// Assumes: codes are prefix-free when read from bit 0 upward.
package dhp_pkg;

    // Number of marker bits in front of the raw escape payload.
    localparam int ESC_PREFIX_W = 5;

    // Code classes selected from the delta magnitude.
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_ONE  = 3'd1,
        CLS_TWO  = 3'd2,
        CLS_MID  = 3'd3,
        CLS_ESC  = 3'd4
    } code_cls_e;

endpackage

// File: rtl/dhp_delta_unit.sv
// Predictor and block-position tracker.
// Produces the wrapped difference between the offered sample and the previous
// accepted sample of the block, and flags the sample that closes the block.
// Assumes: take_i is only high when the sample is actually accepted.
module dhp_delta_unit #(
    parameter int DATA_W    = 8,
    parameter int BLOCK_LEN = 16,
    localparam int CNT_W    = $clog2(BLOCK_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] delta_o,
    output logic              last_o
);

    logic [DATA_W-1:0] prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] prev_eff;
    logic [CNT_W-1:0]  cnt_eff;

    // Effective predictor state: a block start overrides stored values.
    always_comb begin
        prev_eff = blk_start_i ? '0 : prev_q;
        cnt_eff  = blk_start_i ? '0 : cnt_q;
        delta_o  = data_i - prev_eff;
        last_o   = (cnt_eff == CNT_W'(BLOCK_LEN - 1));
    end

    // Update predictor and position on accept or block start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else if (take_i) begin
            prev_q <= data_i;
            cnt_q  <= last_o ? '0 : cnt_eff + CNT_W'(1);
        end else if (blk_start_i) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end
    end

    // R8: a lone block start leaves a cleared predictor and position
    a_r8_predictor_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start_i && !take_i) |=> (prev_q == '0 && cnt_q == '0));

    // R5: the closing sample returns the position to the block start
    a_r5_position_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && last_o) |=> (cnt_q == '0));

    // R9: no accept and no start keeps the predictor
    a_r9_predictor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !blk_start_i) |=> $stable(prev_q) && $stable(cnt_q));

endmodule

// File: rtl/dhp_code_rom.sv
// Fixed prefix-code dictionary, computed rather than stored.
// Maps a wrapped two's-complement delta to a code value (bit 0 sent first)
// and its length. Assumes DATA_W >= 4 so magnitudes up to 6 are representable.
module dhp_code_rom
    import dhp_pkg::*;
#(
    parameter int DATA_W  = 8,
    localparam int CODE_W = DATA_W + ESC_PREFIX_W,
    localparam int LEN_W  = $clog2(CODE_W + 1)
) (
    input  logic [DATA_W-1:0] delta_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o
);

    logic              neg;
    logic [DATA_W-1:0] mag;
    logic [1:0]        mid_idx;
    code_cls_e         cls;

    // Split the delta into sign and magnitude and pick a class.
    always_comb begin
        neg     = delta_i[DATA_W-1];
        mag     = neg ? (~delta_i + DATA_W'(1)) : delta_i;
        mid_idx = mag[1:0] - 2'd3;
        if (mag == DATA_W'(0))
            cls = CLS_ZERO;
        else if (mag == DATA_W'(1))
            cls = CLS_ONE;
        else if (mag == DATA_W'(2))
            cls = CLS_TWO;
        else if (mag >= DATA_W'(3) && mag <= DATA_W'(6) && !(neg && mag[DATA_W-1]))
            cls = CLS_MID;
        else
            cls = CLS_ESC;
    end

    // Emit the code word and its length for the chosen class.
    always_comb begin
        code_o = '0;
        len_o  = '0;
        case (cls)
            CLS_ZERO: begin
                code_o = '0;
                len_o  = LEN_W'(1);
            end
            CLS_ONE: begin
                code_o = neg ? CODE_W'(5) : CODE_W'(1);
                len_o  = LEN_W'(3);
            end
            CLS_TWO: begin
                code_o = neg ? CODE_W'(11) : CODE_W'(3);
                len_o  = LEN_W'(4);
            end
            CLS_MID: begin
                code_o = CODE_W'(7) | (CODE_W'(neg) << 4) | (CODE_W'(mid_idx) << 5);
                len_o  = LEN_W'(7);
            end
            default: begin
                code_o = CODE_W'(15) | (CODE_W'(delta_i) << ESC_PREFIX_W);
                len_o  = LEN_W'(CODE_W);
            end
        endcase
    end

endmodule

// File: rtl/dhp_bit_packer.sv
// Staging buffer with barrel-shift append and flush control.
// Appends each code at the fill pointer. It flushes when a block closes or a
// code would overrun the buffer. When both happen on one sample it stalls the
// input for one cycle to emit the second flush.
// Assumes: take_i implies ready_o, and len_i is in 1..CODE_W with CODE_W <= BUF_W.
module dhp_bit_packer #(
    parameter int BUF_W  = 51,
    parameter int CODE_W = 13,
    parameter int LEN_W  = 4,
    localparam int FILL_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start_i,
    input  logic              take_i,
    input  logic              last_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ready_o,
    output logic              flush_vld_o,
    output logic [BUF_W-1:0]  flush_dat_o,
    output logic [FILL_W-1:0] flush_bits_o,
    output logic              flush_end_o
);

    logic [BUF_W-1:0]  buf_q;
    logic [FILL_W-1:0] fill_q;
    logic              pend_q;

    logic [BUF_W-1:0]  buf_base;
    logic [FILL_W-1:0] fill_base;
    logic [BUF_W-1:0]  code_ext;
    logic [BUF_W-1:0]  appended;
    logic [FILL_W:0]   fill_sum;
    logic              fits;

    // Input is held off only while the second flush of a block is pending.
    assign ready_o = !pend_q;

    // Append path: base state, shifted code, and overflow test.
    always_comb begin
        buf_base  = blk_start_i ? '0 : buf_q;
        fill_base = blk_start_i ? '0 : fill_q;
        code_ext  = BUF_W'(code_i);
        appended  = buf_base | (code_ext << fill_base);
        fill_sum  = {1'b0, fill_base} + (FILL_W + 1)'(len_i);
        fits      = (fill_sum <= (FILL_W + 1)'(BUF_W));
    end

    // Buffer, fill pointer, pending-close flag and registered flush port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q        <= '0;
            fill_q       <= '0;
            pend_q       <= 1'b0;
            flush_vld_o  <= 1'b0;
            flush_dat_o  <= '0;
            flush_bits_o <= '0;
            flush_end_o  <= 1'b0;
        end else begin
            flush_vld_o <= 1'b0;
            flush_end_o <= 1'b0;
            if (take_i) begin
                if (!fits) begin
                    flush_vld_o  <= 1'b1;
                    flush_dat_o  <= buf_base;
                    flush_bits_o <= fill_base;
                    buf_q        <= code_ext;
                    fill_q       <= FILL_W'(len_i);
                    pend_q       <= last_i;
                end else if (last_i) begin
                    flush_vld_o  <= 1'b1;
                    flush_end_o  <= 1'b1;
                    flush_dat_o  <= appended;
                    flush_bits_o <= fill_sum[FILL_W-1:0];
                    buf_q        <= '0;
                    fill_q       <= '0;
                end else begin
                    buf_q  <= appended;
                    fill_q <= fill_sum[FILL_W-1:0];
                end
            end else if (blk_start_i) begin
                buf_q  <= '0;
                fill_q <= '0;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                flush_vld_o  <= 1'b1;
                flush_end_o  <= 1'b1;
                flush_dat_o  <= buf_q;
                flush_bits_o <= fill_q;
                buf_q        <= '0;
                fill_q       <= '0;
                pend_q       <= 1'b0;
            end
        end
    end

    // R4: nothing above the valid bit count is set in a flush
    a_r4_clean_upper: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld_o |-> ((flush_dat_o >> flush_bits_o) == '0));

    // R6: the fill pointer never passes the buffer width
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(BUF_W));

    // R6: every flush carries at least one bit
    a_r6_nonempty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_vld_o |-> (flush_bits_o != '0));

    // R7: a stall cycle is followed by the closing flush
    a_r7_stall_then_close: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !blk_start_i) |=> (flush_vld_o && flush_end_o));

    // R5: a closing flush leaves the buffer empty
    a_r5_close_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_vld_o && flush_end_o) |-> (fill_q == '0));

    // R9: without accept or pending close, no flush follows
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !pend_q) |=> !flush_vld_o);

endmodule

// File: rtl/delta_huff_packer.sv
// Top of the delta Huffman compression packer.
// Accepts one sample per cycle on a valid/ready handshake. It codes the
// in-block delta with a fixed prefix code and packs the codes into a staging
// buffer that is emitted on the flush port.
// Assumes: the flush consumer takes every flush in the cycle it is valid.
module delta_huff_packer
    import dhp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BUF_W     = 51,
    parameter int BLOCK_LEN = 16,
    localparam int CODE_W   = DATA_W + ESC_PREFIX_W,
    localparam int LEN_W    = $clog2(CODE_W + 1),
    localparam int FILL_W   = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start_i,
    input  logic              smp_valid_i,
    output logic              smp_ready_o,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              flush_valid_o,
    output logic [BUF_W-1:0]  flush_data_o,
    output logic [FILL_W-1:0] flush_bits_o,
    output logic              flush_end_o
);

    logic              take;
    logic              last;
    logic [DATA_W-1:0] delta;
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;

    // Handshake: a sample is taken when offered and not stalled.
    assign take = smp_valid_i && smp_ready_o;

    dhp_delta_unit #(
        .DATA_W    (DATA_W),
        .BLOCK_LEN (BLOCK_LEN)
    ) delta_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_start_i (blk_start_i),
        .take_i      (take),
        .data_i      (smp_data_i),
        .delta_o     (delta),
        .last_o      (last)
    );

    dhp_code_rom #(
        .DATA_W (DATA_W)
    ) rom_i (
        .delta_i (delta),
        .code_o  (code),
        .len_o   (len)
    );

    dhp_bit_packer #(
        .BUF_W  (BUF_W),
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W)
    ) pack_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_start_i  (blk_start_i),
        .take_i       (take),
        .last_i       (last),
        .code_i       (code),
        .len_i        (len),
        .ready_o      (smp_ready_o),
        .flush_vld_o  (flush_valid_o),
        .flush_dat_o  (flush_data_o),
        .flush_bits_o (flush_bits_o),
        .flush_end_o  (flush_end_o)
    );

    // R1: out of reset the port is idle and ready
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!flush_valid_o && smp_ready_o));

endmodule

// File: tb/delta_huff_packer_tb.sv
`timescale 1ns/1ps
module delta_huff_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_start_i = 1'b0;
    logic        smp_valid_i = 1'b0;
    logic [7:0]  smp_data_i = 8'h00;
    logic        smp_ready_o;
    logic        flush_valid_o;
    logic [50:0] flush_data_o;
    logic [5:0]  flush_bits_o;
    logic        flush_end_o;

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model state (from the requirements)
    logic [50:0] m_buf  = '0;
    int          m_fill = 0;
    int          m_cnt  = 0;
    logic [7:0]  m_prev = 8'h00;

    always #4 clk = ~clk;

    delta_huff_packer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .blk_start_i   (blk_start_i),
        .smp_valid_i   (smp_valid_i),
        .smp_ready_o   (smp_ready_o),
        .smp_data_i    (smp_data_i),
        .flush_valid_o (flush_valid_o),
        .flush_data_o  (flush_data_o),
        .flush_bits_o  (flush_bits_o),
        .flush_end_o   (flush_end_o)
    );

    // Table block: {start, sample, expected length, expected code} (R2, R3, R6, R10)
    localparam logic [25:0] VEC [16] = '{
        {1'b1, 8'h00, 4'd1,  13'd0},
        {1'b0, 8'h01, 4'd3,  13'd1},
        {1'b0, 8'h00, 4'd3,  13'd5},
        {1'b0, 8'h02, 4'd4,  13'd3},
        {1'b0, 8'h00, 4'd4,  13'd11},
        {1'b0, 8'h05, 4'd7,  13'd71},
        {1'b0, 8'h02, 4'd7,  13'd23},
        {1'b0, 8'h7F, 4'd13, 13'd4015},
        {1'b0, 8'h80, 4'd3,  13'd1},
        {1'b0, 8'h80, 4'd1,  13'd0},
        {1'b0, 8'h86, 4'd7,  13'd103},
        {1'b0, 8'h7F, 4'd13, 13'd7983},
        {1'b0, 8'hFF, 4'd13, 13'd4111},
        {1'b0, 8'h00, 4'd3,  13'd1},
        {1'b0, 8'h00, 4'd1,  13'd0},
        {1'b0, 8'hFF, 4'd3,  13'd5}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Bench code table written from R3
    function automatic void ref_code(input logic [7:0] d, output logic [12:0] c, output int l);
        logic       s;
        logic [7:0] m;
        s = d[7];
        m = s ? 8'(-d) : d;
        if (m == 0)                        begin c = 13'd0; l = 1; end
        else if (m == 1)                   begin c = s ? 13'd5 : 13'd1; l = 3; end
        else if (m == 2)                   begin c = s ? 13'd11 : 13'd3; l = 4; end
        else if (m >= 3 && m <= 6 && d != 8'h80)
                                           begin c = 13'(7 + 16 * s + 32 * (m - 3)); l = 7; end
        else                               begin c = 13'(15 + 32 * d); l = 13; end
    endfunction

    // Offer one sample with its expected code; check the flush port afterwards.
    task automatic push(input logic [7:0] d, input logic st, input logic [12:0] c,
                        input int l, input string tag);
        bit          e_vld = 0, e_end = 0, two = 0;
        logic [50:0] e_dat = '0;
        int          e_bits = 0;
        if (st) begin m_buf = '0; m_fill = 0; m_cnt = 0; end
        if (m_fill + l > 51) begin
            e_vld = 1; e_dat = m_buf; e_bits = m_fill;
            m_buf = 51'(c); m_fill = l;
            two = (m_cnt == 15);
        end else begin
            m_buf = m_buf | (51'(c) << m_fill);
            m_fill = m_fill + l;
            if (m_cnt == 15) begin
                e_vld = 1; e_end = 1; e_dat = m_buf; e_bits = m_fill;
                m_buf = '0; m_fill = 0;
            end
        end
        m_cnt  = (m_cnt == 15) ? 0 : m_cnt + 1;
        m_prev = d;
        blk_start_i = st; smp_valid_i = 1'b1; smp_data_i = d;
        @(posedge clk); @(negedge clk);
        blk_start_i = 1'b0; smp_valid_i = 1'b0;
        chk({tag, " flush_valid"}, 64'(flush_valid_o), 64'(e_vld));
        if (e_vld) begin
            chk({tag, " flush_data"}, 64'(flush_data_o), 64'(e_dat));
            chk({tag, " flush_bits"}, 64'(flush_bits_o), 64'(e_bits));
            chk({tag, " flush_end"},  64'(flush_end_o),  64'(e_end));
        end
        if (two) begin
            chk("R7 ready low during second flush", 64'(smp_ready_o), 64'd0);
            @(posedge clk); @(negedge clk);
            chk("R7 closing flush valid", 64'(flush_valid_o), 64'd1);
            chk("R7 closing flush data",  64'(flush_data_o),  64'(m_buf));
            chk("R7 closing flush bits",  64'(flush_bits_o),  64'(m_fill));
            chk("R7 closing flush end",   64'(flush_end_o),   64'd1);
            chk("R7 ready back high",     64'(smp_ready_o),   64'd1);
            m_buf = '0; m_fill = 0;
        end
    endtask

    task automatic push_auto(input logic [7:0] d, input logic st, input string tag);
        logic [12:0] c;
        int          l;
        ref_code(st ? d : 8'(d - m_prev), c, l);
        push(d, st, c, l, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 flush_valid after reset", 64'(flush_valid_o), 64'd0);
        chk("R1 ready after reset",       64'(smp_ready_o),   64'd1);

        // Table-driven block: codes, wrap, mid/escape edges, one overflow
        for (int i = 0; i < 16; i++) begin
            push(VEC[i][24:17], VEC[i][25], VEC[i][12:0], int'(VEC[i][16:13]),
                 $sformatf("R3/R6/R10 vec%0d", i));
        end

        // R9: invalid cycles with changing data are ignored
        for (int i = 0; i < 3; i++) begin
            smp_data_i = 8'(8'h55 + i);
            @(posedge clk); @(negedge clk);
            chk("R9 no flush on idle", 64'(flush_valid_o), 64'd0);
        end

        // R7: sixteenth sample overflows; earlier overflow mid-block (R6)
        for (int i = 0; i < 16; i++) begin
            if (i < 6)       v = (i % 2 == 0) ? 8'h80 : 8'h00;
            else if (i < 15) v = 8'h00;
            else             v = 8'h80;
            push_auto(v, i == 0, $sformatf("R7 blk s%0d", i));
        end

        // R8: partial block, lone block start, then a full block
        for (int i = 0; i < 5; i++) push_auto(8'(i * 3 + 1), i == 0, "R8 partial");
        blk_start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        blk_start_i = 1'b0;
        chk("R8 no flush on lone start", 64'(flush_valid_o), 64'd0);
        m_buf = '0; m_fill = 0; m_cnt = 0; m_prev = 8'h00;
        v = 8'h40;
        for (int i = 0; i < 16; i++) begin
            v = 8'(v + ((i * 5) % 7) - 3);
            push_auto(v, 1'b0, $sformatf("R2/R8 after start s%0d", i));
        end

        // R8: block start together with a sample mid-block
        for (int i = 0; i < 7; i++) push_auto(8'(8'hF0 + i), 1'b0, "R8 partial2");
        for (int i = 0; i < 16; i++) push_auto(8'(8'h10 - 2 * i), i == 0, "R5/R8 merged start");

        summary();
    end

endmodule